// File: doc/BRIEF.md
# Host-to-Device Burst Write Master

This block moves a host-to-device DMA payload from an internal valid/ready data stream onto a memory-mapped slave as burst write commands. A job is started with a single-cycle `start` strobe that carries a byte start address and a transfer length counted in data words. The block cuts the job into bursts no longer than a width-dependent cap and computes the burst count and burst address itself. The payload passes from the stream to the write data bus without buffering.

Flow control uses the slave's wait-request allowance. When the slave raises `m_waitrequest`, the master does not stop at once. It may keep writing up to a bounded number of further words, and that bound grows as the data width shrinks. Once the bound is used up, the stream is back-pressured until the slave lowers wait-request again. A one-cycle `done` pulse marks the end of each job.

Top module: `h2d_burst_writer`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `m_write` and `s_ready` are all low.
- R2: A burst never carries more than 4096/DATA_W words (8 at 512 bits, 16 at 256, 32 at 128). `m_burstcount` shows the burst length on the first word of a burst and reads 0 on every other word.
- R3: When the length is not a multiple of the cap, every burst except the last is full size, and the last burst carries exactly the remaining words.
- R4: `m_address` stays fixed through a burst. The first burst starts at the start address. Each following burst starts at the previous burst address plus its word count times DATA_W/8.
- R5: While `m_waitrequest` stays high, at most 8192/DATA_W words are written (16 at 512 bits, 32 at 256, 64 at 128). The count restarts from zero in any cycle where `m_waitrequest` is low. Writing resumes in that cycle.
- R6: `s_ready` is high during a job exactly when the next word may be written. `m_write` is high exactly in the cycles where a stream word is accepted. `m_writedata` carries the accepted words in order, with none lost or repeated.
- R7: `done` is high for exactly one cycle, the cycle after the last word of a job was written. `busy` is low in that same cycle.
- R8: A `start` strobe while `busy` is high has no effect on the running job's addresses, burst counts or length.
- R9: A start with length 0 writes nothing and raises `done` for one cycle on the following cycle.
- R10: While no job is running, `s_ready` and `m_write` are low, whatever `s_valid` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a job when idle |
| start_addr | input | ADDR_W | Byte address of the first word |
| total_beats | input | LEN_W | Job length in data words |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| s_data | input | DATA_W | Stream payload word |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Stream word may be taken |
| m_address | output | ADDR_W | Burst byte address |
| m_write | output | 1 | Write word issued |
| m_writedata | output | DATA_W | Write data |
| m_burstcount | output | BC_W | Burst length on the first word, else 0 |
| m_waitrequest | input | 1 | Slave back-pressure |

## Verification
A wrong remaining-word or burst-offset register appears at the ports within one burst. It shows up as a burst count on a middle word, a wrong final burst length, or an address that moves too early or too late. A wrong wait-request counter shows up as `m_write` in the cycle after the allowance was spent, or as a stall before it was spent. Either one is visible in the first hold period longer than the allowance. A fault in job bookkeeping moves the `done` pulse away from the cycle after the last word, so each job exposes it at its end.

// File: rtl/h2d_wr_pkg.sv
package h2d_wr_pkg;

  // Longest burst in words for a given data width.
  function automatic int unsigned burst_cap(input int unsigned width);
    return 4096 / width;
  endfunction

  // Words that may still be written while wait-request is high.
  function automatic int unsigned wait_allowance(input int unsigned width);
    return 8192 / width;
  endfunction

  // Bits needed to hold the value v itself.
  function automatic int unsigned bits_for(input int unsigned v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/h2d_allowance_gate.sv
module h2d_allowance_gate #(
  parameter int unsigned ALLOW = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waitrequest,
  input  logic beat_fire,
  output logic may_issue
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (!waitrequest) begin
      cnt_n  = '0;
      cnt_en = (cnt_q != '0);
    end else if (beat_fire) begin
      cnt_n  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign may_issue = !waitrequest || (cnt_q < CNT_W'(ALLOW));

  // R5: no word once the allowance is spent
  a_r5_allowance_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (waitrequest && (cnt_q >= CNT_W'(ALLOW))) |-> !beat_fire);

  // R5: counter restarts whenever wait-request is low
  a_r5_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !waitrequest |=> (cnt_q == '0));

endmodule

// File: rtl/h2d_burst_planner.sv
module h2d_burst_planner #(
  parameter int unsigned DATA_W    = 512,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned BC_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_beats,
  input  logic              beat_fire,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] wr_address,
  output logic [BC_W-1:0]   wr_burstcount
);

  localparam int unsigned BEAT_SHIFT = $clog2(DATA_W / 8);

  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [BC_W-1:0]   left_q, left_n;
  logic [BC_W-1:0]   blen_q, blen_n;

  logic [BC_W-1:0]   new_len;
  logic [BC_W-1:0]   cur_len;
  logic              first_beat;
  logic              last_in_burst;
  logic              take_start;
  logic              step;
  logic              reg_en;

  assign first_beat    = (left_q == '0);
  assign new_len       = (rem_q < LEN_W'(MAX_BURST)) ? BC_W'(rem_q) : BC_W'(MAX_BURST);
  assign cur_len       = first_beat ? new_len : blen_q;
  assign last_in_burst = first_beat ? (new_len == BC_W'(1)) : (left_q == BC_W'(1));
  assign take_start    = start && !busy_q;
  assign step          = busy_q && beat_fire;
  assign reg_en        = take_start || step || done_q;

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    addr_n = addr_q;
    rem_n  = rem_q;
    left_n = left_q;
    blen_n = blen_q;
    if (take_start) begin
      addr_n = start_addr;
      rem_n  = total_beats;
      left_n = '0;
      blen_n = '0;
      busy_n = (total_beats != '0);
      done_n = (total_beats == '0);
    end else if (step) begin
      rem_n = rem_q - LEN_W'(1);
      if (first_beat) begin
        blen_n = new_len;
        left_n = new_len - BC_W'(1);
      end else begin
        left_n = left_q - BC_W'(1);
      end
      if (last_in_burst) begin
        addr_n = addr_q + (ADDR_W'(cur_len) << BEAT_SHIFT);
      end
      if (rem_q == LEN_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      left_q <= '0;
      blen_q <= '0;
    end else if (reg_en) begin
      busy_q <= busy_n;
      done_q <= done_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
      left_q <= left_n;
      blen_q <= blen_n;
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign wr_address    = addr_q;
  assign wr_burstcount = (busy_q && first_beat) ? new_len : '0;

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: a running job changes only when a word is written
  a_r8_job_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !beat_fire) |=> ($stable(rem_q) && $stable(addr_q)));

  // R2: middle words of a burst carry no burst count
  a_r2_mid_burst_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (left_q != '0)) |-> (wr_burstcount == '0));

  // R3: a running job always has words left
  a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));

endmodule

// File: rtl/h2d_burst_writer.sv
module h2d_burst_writer #(
  parameter int unsigned DATA_W = 512,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned MAX_BURST = h2d_wr_pkg::burst_cap(DATA_W),
  localparam int unsigned ALLOW     = h2d_wr_pkg::wait_allowance(DATA_W),
  localparam int unsigned BC_W      = h2d_wr_pkg::bits_for(MAX_BURST),
  localparam int unsigned CNT_W     = h2d_wr_pkg::bits_for(ALLOW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_beats,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [ADDR_W-1:0] m_address,
  output logic              m_write,
  output logic [DATA_W-1:0] m_writedata,
  output logic [BC_W-1:0]   m_burstcount,
  input  logic              m_waitrequest
);

  logic may_issue;
  logic beat_fire;
  logic busy_i;

  h2d_burst_planner #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_BURST (MAX_BURST),
    .BC_W      (BC_W)
  ) u_plan (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_addr    (start_addr),
    .total_beats   (total_beats),
    .beat_fire     (beat_fire),
    .busy          (busy_i),
    .done          (done),
    .wr_address    (m_address),
    .wr_burstcount (m_burstcount)
  );

  h2d_allowance_gate #(
    .ALLOW (ALLOW),
    .CNT_W (CNT_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .waitrequest (m_waitrequest),
    .beat_fire   (beat_fire),
    .may_issue   (may_issue)
  );

  assign s_ready     = busy_i && may_issue;
  assign beat_fire   = s_valid && s_ready;
  assign m_write     = beat_fire;
  assign m_writedata = s_data;
  assign busy        = busy_i;

  // R6: every write is an accepted stream word
  a_r6_write_is_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> (s_valid && s_ready));

  // R10: idle block neither takes nor writes words
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (!s_ready && !m_write));

endmodule

// File: tb/tb_h2d_burst_writer.sv
module tb_h2d_burst_writer;

  localparam int DATA_W = 512;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXB   = 4096 / DATA_W;
  localparam int ALLOW  = 8192 / DATA_W;
  localparam int BYTES  = DATA_W / 8;
  localparam int BC_W   = $clog2(MAXB + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  total_beats;
  logic              busy, done;
  logic [DATA_W-1:0] s_data;
  logic              s_valid, s_ready;
  logic [ADDR_W-1:0] m_address;
  logic              m_write;
  logic [DATA_W-1:0] m_writedata;
  logic [BC_W-1:0]   m_burstcount;
  logic              m_waitrequest;

  int n_checks = 0;
  int n_fail   = 0;
  int hold_beats;

  always #5 clk = ~clk;

  h2d_burst_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .total_beats(total_beats), .busy(busy), .done(done), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .m_address(m_address),
    .m_write(m_write), .m_writedata(m_writedata), .m_burstcount(m_burstcount),
    .m_waitrequest(m_waitrequest)
  );

  // addr[31:0], len[15:0], valid mode[1:0], wait mode[1:0]
  localparam int NVEC = 6;
  localparam logic [51:0] VEC [NVEC] = '{
    {32'h0000_1000, 16'd8,  2'd0, 2'd0},
    {32'h0000_0000, 16'd21, 2'd0, 2'd0},
    {32'h0004_0000, 16'd3,  2'd1, 2'd0},
    {32'h0000_2000, 16'd50, 2'd0, 2'd1},
    {32'h0000_8000, 16'd17, 2'd1, 2'd1},
    {32'h0012_3400, 16'd1,  2'd0, 2'd0}
  };

  function automatic logic [DATA_W-1:0] word_of(input int i);
    return {(DATA_W/32){32'hC0DE_0000 + i}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] a, input int n, input int vm,
                          input int wm, input bit poke);
    int idx = 0;
    int src = 0;
    int cyc = 0;
    int wr_run = 0;
    bit exp_wr;
    hold_beats = 0;
    @(posedge clk); #1;
    start = 1'b1; start_addr = a; total_beats = LEN_W'(n);
    s_valid = 1'b0; m_waitrequest = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    while (idx < n && cyc < 2000) begin
      s_valid = (vm == 0) || (cyc % 2 == 1);
      s_data  = word_of(src);
      if (wm == 1)      m_waitrequest = (cyc % 25) >= 5;
      else if (wm == 2) m_waitrequest = (cyc < 30);
      else              m_waitrequest = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; start_addr = a ^ 32'h00F0_0000; total_beats = 16'd7;
      end else begin
        start = 1'b0;
      end
      #3;
      exp_wr = s_valid && (!m_waitrequest || wr_run < ALLOW);
      chk(m_write == exp_wr, "R5/R6 write gating", 64'(m_write), 64'(exp_wr));
      chk(s_ready == (!m_waitrequest || wr_run < ALLOW), "R6 ready",
          64'(s_ready), 64'(!m_waitrequest || wr_run < ALLOW));
      if (m_write) begin
        int b    = idx / MAXB;
        int off  = idx % MAXB;
        int blen = (n - b * MAXB) < MAXB ? (n - b * MAXB) : MAXB;
        logic [31:0] ea = a + 32'(b * MAXB * BYTES);
        int ebc  = (off == 0) ? blen : 0;
        chk(m_address == ea, poke ? "R8 address" : "R4 address",
            64'(m_address), 64'(ea));
        chk(int'(m_burstcount) == ebc, (blen < MAXB) ? "R3 burstcount" : "R2 burstcount",
            64'(m_burstcount), 64'(ebc));
        chk(m_writedata == word_of(idx), "R6 data order",
            m_writedata[63:0], word_of(idx) & 64'hFFFF_FFFF_FFFF_FFFF);
        if (wm == 2 && cyc < 30) hold_beats++;
        idx++;
      end
      if (s_valid && s_ready) src++;
      wr_run = !m_waitrequest ? 0 : wr_run + int'(m_write);
      cyc++;
      @(posedge clk); #1;
    end
    chk(idx == n, "R6 word count", 64'(idx), 64'(n));
    start = 1'b0; s_valid = 1'b0; m_waitrequest = 1'b0;
    #3;
    chk(done == 1'b1, "R7 done after last word", 64'(done), 64'd1);
    chk(busy == 1'b0, "R7 busy low with done", 64'(busy), 64'd0);
    @(posedge clk); #1;
    s_valid = 1'b1;
    #3;
    chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
    chk(s_ready == 1'b0 && m_write == 1'b0, "R10 idle ignores valid",
        64'({s_ready, m_write}), 64'd0);
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; total_beats = '0;
    s_data = '0; s_valid = 1'b1; m_waitrequest = 1'b0;
    repeat (3) @(posedge clk);
    #4;
    chk({busy, done, m_write, s_ready} == 4'b0, "R1 reset outputs",
        64'({busy, done, m_write, s_ready}), 64'd0);
    #2 rst_n = 1'b1;
    @(posedge clk); #4;
    chk({busy, done, m_write, s_ready} == 4'b0, "R1 after reset",
        64'({busy, done, m_write, s_ready}), 64'd0);
    s_valid = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      run_xfer(VEC[v][51:20], int'(VEC[v][19:4]), int'(VEC[v][3:2]),
               int'(VEC[v][1:0]), 1'b0);
    end

    // R5: wait-request held high for 30 cycles with a word always offered
    run_xfer(32'h0010_0000, 40, 0, 2, 1'b0);
    chk(hold_beats == ALLOW, "R5 allowance during hold", 64'(hold_beats), 64'(ALLOW));

    // R8: start strobe in the middle of a job
    run_xfer(32'h0020_0000, 19, 0, 0, 1'b1);

    // R9: zero-length job
    @(posedge clk); #1;
    start = 1'b1; start_addr = 32'h0000_4000; total_beats = '0;
    @(posedge clk); #1;
    start = 1'b0; s_valid = 1'b1;
    #3;
    chk(done == 1'b1, "R9 done for empty job", 64'(done), 64'd1);
    chk(m_write == 1'b0 && busy == 1'b0, "R9 nothing written",
        64'({m_write, busy}), 64'd0);
    @(posedge clk); #4;
    chk(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
    chk(m_write == 1'b0, "R10 no write while idle", 64'(m_write), 64'd0);
    s_valid = 1'b0;

    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule